// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the low address bits of a fixed-length burst for a synchronous memory port. A controller loads a starting value. On each later clock edge where the active-low advance input is low, the block steps to the next beat of the burst. The output address is held while advance stays high, so a burst can be suspended for any number of cycles.

Two beat orders are supported. Linear order counts upward from the start and wraps modulo the burst length. Interleaved order XORs the start with a running beat index. The order-select input is captured on each load, so a change on that input in the middle of a burst does not affect the burst in flight. After the final beat, one more advance returns the address to the starting value. A new start may be loaded on every cycle with no idle cycle between loads.

Top module: `burst_addr_gen`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) sets addr_o to 0 and last_o to 0, and clears the stored start and the beat index to 0.
- R2: At the edge after a cycle with load_i high, addr_o equals the start_i value presented in that cycle, last_o is 0, and the beat index restarts at 0.
- R3: When load_i and an advance (adv_n_i low) occur in the same cycle, the load wins: addr_o takes start_i and does not step.
- R4: With lin_n_i = 0 captured at load, beat k (k = 0..3) outputs (start + k) mod 4, for example start 01 gives 01,10,11,00.
- R5: With lin_n_i = 1 captured at load, beat k outputs start XOR k, for example start 01 gives 01,00,11,10.
- R6: An edge with load_i low and adv_n_i high leaves addr_o and last_o unchanged.
- R7: last_o is 1 exactly while the beat index is 3 (the fourth address of the burst).
- R8: An advance from the fourth beat returns addr_o to the starting value and clears last_o.
- R9: The order is sampled only at load. Changing lin_n_i during a burst does not change the sequence until the next load.
- R10: Loads on consecutive cycles each present their own start value at the next edge, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Loads a new starting value, active high |
| start_i | input | W | Starting low address |
| adv_n_i | input | 1 | Steps to the next beat when low |
| lin_n_i | input | 1 | Order select: 0 linear, 1 interleaved (captured at load) |
| addr_o | output | W | Current low address, registered |
| last_o | output | 1 | High on the final beat, registered |

## Verification
The embedded properties assume that every input is a clean, settled logic level at each rising edge. They also take the order used in a step from the value latched at the previous load, never from the live select pin. The stimulus changes inputs one nanosecond after each rising edge and never leaves them unknown. The stimulus also drives reset in the middle of a burst, so the properties must resume correctly from the cleared state.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Beat ordering, encoded to match the select pin level
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  localparam order_e ORD_RESET = ORD_INTERLEAVE;

endpackage

// File: rtl/burst_map.sv
module burst_map
  import burst_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] beat_i,
  input  order_e       order_i,
  output logic [W-1:0] addr_o,
  output logic         last_o
);

  logic [W-1:0] lin_addr;
  logic [W-1:0] xor_addr;

  // Linear: modular add, carry out dropped
  assign lin_addr = base_i + beat_i;

  // Interleaved: bitwise toggle of the start by the beat index
  for (genvar b = 0; b < W; b++) begin : g_xor
    assign xor_addr[b] = base_i[b] ^ beat_i[b];
  end

  always_comb begin
    if (order_i == ORD_LINEAR) addr_o = lin_addr;
    else                       addr_o = xor_addr;
  end

  assign last_o = &beat_i;

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] start_i,
  input  logic         adv_n_i,
  input  logic         lin_n_i,
  output logic [W-1:0] start_q,
  output order_e       order_q,
  output logic [W-1:0] nxt_start,
  output logic [W-1:0] nxt_beat,
  output order_e       nxt_order
);

  logic [W-1:0] beat_q;

  always_comb begin
    nxt_start = start_q;
    nxt_beat  = beat_q;
    nxt_order = order_q;
    if (load_i) begin
      nxt_start = start_i;
      nxt_beat  = '0;
      nxt_order = order_e'(lin_n_i);
    end else if (!adv_n_i) begin
      nxt_beat  = beat_q + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
      order_q <= ORD_RESET;
    end else begin
      start_q <= nxt_start;
      beat_q  <= nxt_beat;
      order_q <= nxt_order;
    end
  end

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> ($stable(beat_q) && $stable(start_q)));

  // R9
  order_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(order_q));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] start_i,
  input  logic         adv_n_i,
  input  logic         lin_n_i,
  output logic [W-1:0] addr_o,
  output logic         last_o
);

  logic [W-1:0] start_q;
  order_e       order_q;
  logic [W-1:0] nxt_start;
  logic [W-1:0] nxt_beat;
  order_e       nxt_order;
  logic [W-1:0] map_addr;
  logic         map_last;

  burst_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_i),
    .start_i   (start_i),
    .adv_n_i   (adv_n_i),
    .lin_n_i   (lin_n_i),
    .start_q   (start_q),
    .order_q   (order_q),
    .nxt_start (nxt_start),
    .nxt_beat  (nxt_beat),
    .nxt_order (nxt_order)
  );

  burst_map #(.W(W)) u_map (
    .base_i  (nxt_start),
    .beat_i  (nxt_beat),
    .order_i (nxt_order),
    .addr_o  (map_addr),
    .last_o  (map_last)
  );

  // Outputs registered from next-state mapping: no logic after the flops
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      last_o <= 1'b0;
    end else begin
      addr_o <= map_addr;
      last_o <= map_last;
    end
  end

  // R2 R3 R10
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(start_i)) && !last_o);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(last_o)));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (last_o && !load_i && !adv_n_i) |=> (!last_o && addr_o == start_q));

  // R4
  lin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && order_q == ORD_LINEAR)
      |=> addr_o == W'($past(addr_o) + W'(1)));

  // R5
  xor_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && order_q == ORD_INTERLEAVE)
      |=> (addr_o ^ start_q) == W'(($past(addr_o) ^ $past(start_q)) + W'(1)));

endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [W-1:0] start_i = '0;
  logic         adv_n_i = 1'b1;
  logic         lin_n_i = 1'b1;
  logic [W-1:0] addr_o;
  logic         last_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.W(W)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .start_i(start_i),
    .adv_n_i(adv_n_i), .lin_n_i(lin_n_i), .addr_o(addr_o), .last_o(last_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic ld, input logic [W-1:0] s, input logic adv_n, input logic lin_n);
    load_i = ld; start_i = s; adv_n_i = adv_n; lin_n_i = lin_n;
  endtask

  task automatic chk(input string req, input logic [W-1:0] exp_a, input logic exp_l);
    checks++;
    if (addr_o !== exp_a || last_o !== exp_l) begin
      errors++;
      $display("FAIL %s: addr=%0d last=%0b expected addr=%0d last=%0b",
               req, addr_o, last_o, exp_a, exp_l);
    end
  endtask

  // R1: reset state, then a plain advance run from the cleared start
  task automatic t_reset();
    drive(1'b0, '0, 1'b1, 1'b1);
    rst = 1'b1; tick(); tick();
    chk("R1", 0, 0);
    rst = 1'b0;
    for (int k = 1; k < 4; k++) begin
      drive(1'b0, '0, 1'b0, 1'b1); tick();
      chk("R7", W'(k), k == 3);
    end
    drive(1'b0, '0, 1'b1, 1'b1);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1", 0, 0);
  endtask

  // R4 / R5 / R7 / R8: full bursts from every start in both orders
  task automatic t_order_run(input logic lin_n);
    for (int s = 0; s < 4; s++) begin
      drive(1'b1, W'(s), 1'b1, lin_n); tick();
      chk("R2", W'(s), 0);
      for (int k = 1; k < 4; k++) begin
        drive(1'b0, '0, 1'b0, lin_n); tick();
        if (lin_n) chk("R5", W'(s ^ k), k == 3);
        else       chk("R4", W'(s + k), k == 3);
      end
      drive(1'b0, '0, 1'b0, lin_n); tick();
      chk("R8", W'(s), 0);
    end
  endtask

  // R6: suspend holds address and flag
  task automatic t_hold();
    drive(1'b1, 2'd2, 1'b1, 1'b0); tick();
    drive(1'b0, '0, 1'b0, 1'b0); tick();
    chk("R4", 3, 0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 2'd1, 1'b1, 1'b1); tick();
      chk("R6", 3, 0);
    end
    drive(1'b0, '0, 1'b0, 1'b0); tick();
    chk("R4", 0, 0);
    drive(1'b0, '0, 1'b0, 1'b0); tick();
    chk("R7", 1, 1);
    drive(1'b0, '0, 1'b1, 1'b0); tick();
    chk("R6", 1, 1);
  endtask

  // R3: load beats a simultaneous advance
  task automatic t_prio();
    drive(1'b1, 2'd1, 1'b1, 1'b1); tick();
    drive(1'b0, '0, 1'b0, 1'b1); tick();
    chk("R5", 0, 0);
    drive(1'b1, 2'd2, 1'b0, 1'b1); tick();
    chk("R3", 2, 0);
    drive(1'b0, '0, 1'b0, 1'b1); tick();
    chk("R3", 3, 0);
  endtask

  // R9: select pin changes mid-burst are ignored
  task automatic t_order_latch();
    drive(1'b1, 2'd1, 1'b1, 1'b0); tick();
    drive(1'b0, '0, 1'b0, 1'b1); tick();
    chk("R9", 2, 0);
    drive(1'b0, '0, 1'b0, 1'b1); tick();
    chk("R9", 3, 0);
    drive(1'b0, '0, 1'b0, 1'b1); tick();
    chk("R9", 0, 1);
  endtask

  // R10: a new load on every cycle
  task automatic t_b2b();
    logic [W-1:0] seq [4] = '{2'd3, 2'd0, 2'd2, 2'd1};
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, seq[i], 1'b0, i[0]); tick();
      chk("R10", seq[i], 0);
    end
    drive(1'b0, '0, 1'b0, 1'b1); tick();
    chk("R10", 0, 0);
  endtask

  initial begin
    t_reset();
    t_order_run(1'b0);
    t_order_run(1'b1);
    t_hold();
    t_prio();
    t_order_latch();
    t_b2b();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule